// File: doc/BRIEF.md
# Mains-Locked Sample Strobe Generator

This block issues analog-to-digital sample requests at a fixed whole number of samples per mains cycle, and it follows the grid frequency as that frequency drifts. The block runs entirely from a fast system clock. A digital phase accumulator advances by a frequency word on every clock. Each time the selected number of top accumulator bits steps to a new value, a one-cycle sample strobe goes out. The current value of those bits is presented as the sample index within the cycle.

An external comparator turns the mains zero crossing into a digital reference pulse. The block synchronises the rising edge of that pulse and blanks any further edges for a holdoff window. Each accepted edge latches the accumulator as a signed phase error. A shift-based proportional-integral filter then retunes the frequency word. At the same edge the accumulator restarts, so the full phase error is absorbed at the edge rather than spread across the cycle. The frequency word is confined to the band for 48 to 52 Hz. A lock flag reports whether recent edges landed close to the expected phase.

With the default parameters and a 100 MHz clock, the nominal word corresponds to 50 Hz. The clamp limits correspond to 48 Hz and 52 Hz. The word step is well below 0.01 Hz.

Top module: `mains_strobe_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, the frequency word equals FW_NOM, the lock flag is 0, the sample index is 0 and the strobe is 0.
- R2: The strobe is high for exactly one clock each time the sample index takes a new value, including the return to 0. With the loop settled on a steady reference, exactly N strobes occur in every reference period.
- R3: The rate select picks N as follows: code 0 gives 64, code 1 gives 128, code 2 gives 256 and code 3 gives 64. The sample index is the top log2(N) bits of the ACC_W-bit accumulator.
- R4: The frequency word changes only at accepted edges. At an accepted edge, the error e is the accumulator read as a signed number. The integrator becomes integ minus (e arithmetic-shifted right by the integral shift). The new word is that integrator value minus e shifted right by the proportional shift, with the proportional shift rounded toward zero. For a steady reference period of P clocks, the word therefore settles to the smallest value w with P·w ≥ 2^ACC_W, provided the residual is below 2^(integral shift).
- R5: The frequency word never leaves [FW_MIN, FW_MAX]. When an edge computes a word outside that band, the word holds at the violated limit and the lock flag is 0 from the next cycle.
- R6: The lock flag rises after 4 consecutive accepted edges whose |e| is strictly below the threshold input. It falls after 2 consecutive edges that miss that test. It changes only at accepted edges.
- R7: The reference passes through a two-flop synchroniser, so an edge is accepted on the third clock after the input is first sampled high. Rising edges within HOLDOFF clocks of an accepted edge are ignored.
- R8: An accepted edge reloads the accumulator with the current word, so the index is 0 on the next cycle. It then counts 0 to N−1 and wraps with the accumulator. On a settled 1024-clock period with word 1024 and ACC_W = 20, the index is N/2 at the 512th cycle after that reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Zero-crossing reference pulse from comparator |
| rate_sel | input | 2 | Samples-per-cycle code (R3) |
| kp_shift | input | 5 | Proportional gain as right-shift amount |
| ki_shift | input | 5 | Integral gain as right-shift amount |
| lock_thr | input | ACC_W | Phase-error magnitude threshold for lock |
| strobe_o | output | 1 | One-cycle sample request |
| index_o | output | 8 | Sample index within the mains cycle |
| fw_o | output | ACC_W | Current frequency word |
| locked_o | output | 1 | Loop lock flag |

## Verification
Two events can fall in the same clock: the accumulator wrapping past its top, and the phase restart forced by an accepted reference edge. The bench provokes this by feeding a reference period of exactly 1024 clocks while the word settles at 1024. The wrap and the reload then coincide on every edge. Steady references whose word overshoots or undershoots the wrap by a few steps give the near-miss cases. Each case is judged by counting strobes over one full reference period, where anything other than N means a doubled or lost strobe. The index is also sampled at mid-period.

// File: rtl/mains_sg_pkg.sv
package mains_sg_pkg;

    localparam int IDX_W           = 8;
    localparam int LOCK_GOOD_EDGES = 4;
    localparam int LOCK_BAD_EDGES  = 2;

    typedef enum logic [1:0] {
        RATE_64    = 2'd0,
        RATE_128   = 2'd1,
        RATE_256   = 2'd2,
        RATE_ALT64 = 2'd3
    } rate_sel_e;

    typedef struct packed {
        logic below_thr;
        logic clamped;
    } edge_verdict_t;

    function automatic logic [3:0] rate_log2(input rate_sel_e s);
        case (s)
            RATE_128: return 4'd7;
            RATE_256: return 4'd8;
            default:  return 4'd6;
        endcase
    endfunction

endpackage

// File: rtl/ref_edge_qual.sv
module ref_edge_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLDOFF     = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic accept_o
);
    localparam int HO_W = $clog2(HOLDOFF + 1);

    logic [SYNC_STAGES:0] stg_q;
    logic [HO_W-1:0]      hold_q;
    logic                 rise;

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= {stg_q[SYNC_STAGES-1:0], ref_in};
    end

    assign rise     = stg_q[SYNC_STAGES-1] & ~stg_q[SYNC_STAGES];
    assign accept_o = rise && (hold_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                hold_q <= '0;
        else if (accept_o)      hold_q <= HO_W'(HOLDOFF);
        else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
    end

    // R7: an accepted edge opens a blanking window
    p_holdoff_gap_r7: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o);

endmodule

// File: rtl/phase_accum.sv
module phase_accum
    import mains_sg_pkg::*;
#(
    parameter int ACC_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] fw_i,
    input  logic             restart_i,
    input  rate_sel_e        rate_i,
    output logic             strobe_o,
    output logic [IDX_W-1:0] index_o,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_q;
    logic [IDX_W-1:0] prev_top_q;
    logic [IDX_W-1:0] top_now;
    logic [IDX_W-1:0] idx_prev;
    logic [3:0]       drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            prev_top_q <= '0;
        end else begin
            acc_q      <= restart_i ? fw_i : acc_q + fw_i;
            prev_top_q <= top_now;
        end
    end

    always_comb begin
        top_now  = acc_q[ACC_W-1 -: IDX_W];
        drop     = 4'(IDX_W) - rate_log2(rate_i);
        index_o  = top_now >> drop;
        idx_prev = prev_top_q >> drop;
        strobe_o = (index_o != idx_prev);
    end

    assign acc_o = acc_q;

    // R8: the cycle after a restart starts at index zero
    p_restart_index0_r8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (index_o == '0));

endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter #(
    parameter int ACC_W  = 36,
    parameter int FW_NOM = 34360,
    parameter int FW_MIN = 32985,
    parameter int FW_MAX = 35734
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    edge_i,
    input  logic [ACC_W-1:0]        acc_i,
    input  logic [4:0]              kp_shift,
    input  logic [4:0]              ki_shift,
    output logic [ACC_W-1:0]        fw_o,
    output logic signed [ACC_W-1:0] err_o,
    output logic                    clamp_o
);
    localparam int W = ACC_W + 2;
    typedef logic signed [W-1:0] wide_t;
    localparam wide_t LO  = wide_t'(FW_MIN);
    localparam wide_t HI  = wide_t'(FW_MAX);
    localparam wide_t NOM = wide_t'(FW_NOM);

    wide_t integ_q, fw_q;
    wide_t err_w, i_step, p_step, integ_raw, integ_sat, fw_raw, fw_sat;
    logic signed [ACC_W-1:0] err_s;

    always_comb begin
        err_s  = acc_i;
        err_w  = wide_t'(err_s);
        i_step = err_w >>> ki_shift;
        p_step = err_w[W-1] ? -((-err_w) >>> kp_shift) : (err_w >>> kp_shift);

        integ_raw = integ_q - i_step;
        if (integ_raw < LO)      integ_sat = LO;
        else if (integ_raw > HI) integ_sat = HI;
        else                     integ_sat = integ_raw;

        fw_raw  = integ_sat - p_step;
        clamp_o = (fw_raw < LO) || (fw_raw > HI);
        if (fw_raw < LO)      fw_sat = LO;
        else if (fw_raw > HI) fw_sat = HI;
        else                  fw_sat = fw_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= NOM;
            fw_q    <= NOM;
        end else if (edge_i) begin
            integ_q <= integ_sat;
            fw_q    <= fw_sat;
        end
    end

    assign fw_o  = fw_q[ACC_W-1:0];
    assign err_o = err_s;

    // R5: word stays inside the tracking band
    p_fw_in_band_r5: assert property (@(posedge clk) disable iff (rst)
        (fw_q >= LO) && (fw_q <= HI));
    // R4: word retunes only at accepted edges
    p_fw_holds_r4: assert property (@(posedge clk) disable iff (rst)
        !edge_i |=> $stable(fw_q));

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
    import mains_sg_pkg::*;
#(
    parameter int ACC_W = 36
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    edge_i,
    input  logic signed [ACC_W-1:0] err_i,
    input  logic                    clamp_i,
    input  logic [ACC_W-1:0]        thr_i,
    output logic                    locked_o
);
    logic signed [ACC_W:0] err_ext;
    logic [ACC_W:0]        mag;
    edge_verdict_t         verdict;
    logic [2:0]            good_q;
    logic [1:0]            bad_q;

    always_comb begin
        err_ext           = {err_i[ACC_W-1], err_i};
        mag               = (err_ext < 0) ? (ACC_W+1)'(-err_ext) : (ACC_W+1)'(err_ext);
        verdict.clamped   = clamp_i;
        verdict.below_thr = !clamp_i && (mag < {1'b0, thr_i});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q   <= '0;
            bad_q    <= '0;
            locked_o <= 1'b0;
        end else if (edge_i) begin
            if (verdict.below_thr) begin
                bad_q <= '0;
                if (good_q != 3'(LOCK_GOOD_EDGES)) good_q <= good_q + 3'd1;
                if (good_q + 3'd1 >= 3'(LOCK_GOOD_EDGES)) locked_o <= 1'b1;
            end else begin
                good_q <= '0;
                if (bad_q != 2'(LOCK_BAD_EDGES)) bad_q <= bad_q + 2'd1;
                if (verdict.clamped || (bad_q + 2'd1 >= 2'(LOCK_BAD_EDGES)))
                    locked_o <= 1'b0;
            end
        end
    end

    // R6: lock changes only as a result of an accepted edge
    p_lock_held_between_edges_r6: assert property (@(posedge clk) disable iff (rst)
        !edge_i |=> $stable(locked_o));
    p_lock_rise_at_edge_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(edge_i));
    // R5: a clamped edge forces the lock flag low
    p_clamp_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_i && clamp_i) |=> !locked_o);

endmodule

// File: rtl/mains_strobe_gen.sv
module mains_strobe_gen
    import mains_sg_pkg::*;
#(
    parameter int ACC_W       = 36,
    parameter int FW_NOM      = 34360,
    parameter int FW_MIN      = 32985,
    parameter int FW_MAX      = 35734,
    parameter int HOLDOFF     = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic [1:0]       rate_sel,
    input  logic [4:0]       kp_shift,
    input  logic [4:0]       ki_shift,
    input  logic [ACC_W-1:0] lock_thr,
    output logic             strobe_o,
    output logic [7:0]       index_o,
    output logic [ACC_W-1:0] fw_o,
    output logic             locked_o
);
    logic                    edge_ok;
    logic [ACC_W-1:0]        acc;
    logic [ACC_W-1:0]        fw;
    logic signed [ACC_W-1:0] err;
    logic                    clamp;
    logic [IDX_W-1:0]        idx;
    rate_sel_e               rate;

    assign rate = rate_sel_e'(rate_sel);

    ref_edge_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLDOFF(HOLDOFF)) u_edge (
        .clk(clk), .rst(rst), .ref_in(ref_in), .accept_o(edge_ok)
    );

    phase_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .fw_i(fw), .restart_i(edge_ok), .rate_i(rate),
        .strobe_o(strobe_o), .index_o(idx), .acc_o(acc)
    );

    pi_loop_filter #(.ACC_W(ACC_W), .FW_NOM(FW_NOM), .FW_MIN(FW_MIN), .FW_MAX(FW_MAX)) u_pi (
        .clk(clk), .rst(rst), .edge_i(edge_ok), .acc_i(acc),
        .kp_shift(kp_shift), .ki_shift(ki_shift),
        .fw_o(fw), .err_o(err), .clamp_o(clamp)
    );

    lock_tracker #(.ACC_W(ACC_W)) u_lock (
        .clk(clk), .rst(rst), .edge_i(edge_ok), .err_i(err), .clamp_i(clamp),
        .thr_i(lock_thr), .locked_o(locked_o)
    );

    assign index_o = 8'(idx);
    assign fw_o    = fw;

endmodule

// File: tb/tb_mains_strobe_gen.sv
module tb_mains_strobe_gen;
    localparam int AW   = 20;
    localparam int NOMW = 1024;
    localparam int LOW  = 983;
    localparam int HIW  = 1065;
    localparam int HOLD = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_in = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic [4:0]    kp_shift = 5'd14;
    logic [4:0]    ki_shift = 5'd10;
    logic [AW-1:0] lock_thr = AW'(2048);
    logic          strobe;
    logic [7:0]    idx;
    logic [AW-1:0] fw;
    logic          locked;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mains_strobe_gen #(.ACC_W(AW), .FW_NOM(NOMW), .FW_MIN(LOW), .FW_MAX(HIW),
                       .HOLDOFF(HOLD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .rate_sel(rate_sel),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .lock_thr(lock_thr),
        .strobe_o(strobe), .index_o(idx), .fw_o(fw), .locked_o(locked)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One reference period of p clocks; counts strobes over p cycles and
    // samples the index 512 cycles after the phase reload.
    task automatic run_period(input int p, input bit glitch, output int scnt, output int mid);
        scnt = 0;
        mid  = -1;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (strobe) scnt++;
            if (i == 514) mid = int'(idx);
            if (glitch) ref_in = (i < 20) || (i >= 30 && i < p / 2);
            else        ref_in = (i < p / 2);
        end
    endtask

    task automatic settle(input int p, input int n);
        int sc, md;
        for (int k = 0; k < n; k++) run_period(p, 1'b0, sc, md);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL R2 watchdog: got %0d cycles expected completion", 190000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int sc, md;
        int plist[5] = '{990, 1000, 1040, 1060, 995};
        int nlist[4] = '{64, 128, 256, 64};

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(fw == AW'(NOMW), "R1", "reset word", fw, NOMW);
        chk(locked == 1'b0, "R1", "reset lock", locked, 0);
        chk(idx == 8'd0, "R1", "reset index", idx, 0);
        chk(strobe == 1'b0, "R1", "reset strobe", strobe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fw == AW'(NOMW) && !locked, "R1", "first cycle after reset", fw, NOMW);

        settle(1024, 12);

        // R3 / R2 / R8: every rate code at a settled 1024-clock period
        for (int c = 0; c < 4; c++) begin
            rate_sel = 2'(c);
            run_period(1024, 1'b0, sc, md);
            run_period(1024, 1'b0, sc, md);
            chk(sc == nlist[c], "R3", "strobes per period for rate code", sc, nlist[c]);
            chk(md == nlist[c] / 2, "R8", "mid-period index", md, nlist[c] / 2);
        end
        rate_sel = 2'd0;
        chk(fw == AW'(NOMW), "R4", "settled word at 1024", fw, NOMW);
        chk(locked == 1'b1, "R6", "locked at nominal", locked, 1);

        // R7: a second rising edge inside the holdoff window is ignored
        run_period(1024, 1'b1, sc, md);
        chk(sc == 64, "R7", "strobes with glitch", sc, 64);
        chk(fw == AW'(NOMW), "R7", "word after glitch", fw, NOMW);
        chk(locked == 1'b1, "R7", "lock after glitch", locked, 1);
        run_period(1024, 1'b0, sc, md);
        chk(md == 32, "R7", "index alignment after glitch", md, 32);

        // R4 / R2: sweep of steady periods inside the band
        foreach (plist[j]) begin
            longint efw;
            efw = ((64'd1 << AW) + longint'(plist[j]) - 1) / longint'(plist[j]);
            settle(plist[j], 12);
            run_period(plist[j], 1'b0, sc, md);
            chk(longint'(fw) == efw, "R4", "settled word", fw, efw);
            chk(locked == 1'b1, "R6", "locked in sweep", locked, 1);
            chk(sc == 64, "R2", "strobes per period in sweep", sc, 64);
        end

        // R5: references outside the band pin the word and drop lock
        settle(900, 6);
        chk(fw == AW'(HIW), "R5", "word clamped high", fw, HIW);
        chk(locked == 1'b0, "R5", "lock low when clamped high", locked, 0);
        settle(1200, 6);
        chk(fw == AW'(LOW), "R5", "word clamped low", fw, LOW);
        chk(locked == 1'b0, "R5", "lock low when clamped low", locked, 0);

        // R6: lock hysteresis counted edge by edge
        settle(1024, 12);
        chk(locked == 1'b1, "R6", "relocked", locked, 1);
        lock_thr = '0;
        run_period(1024, 1'b0, sc, md);
        chk(locked == 1'b1, "R6", "one miss keeps lock", locked, 1);
        run_period(1024, 1'b0, sc, md);
        chk(locked == 1'b0, "R6", "two misses drop lock", locked, 0);
        lock_thr = AW'(2048);
        for (int k = 1; k <= 4; k++) begin
            run_period(1024, 1'b0, sc, md);
            chk(locked == (k == 4), "R6", "lock after good edges", locked, (k == 4) ? 1 : 0);
        end
        chk(sc == 64, "R2", "strobes while relocking", sc, 64);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule